// File: doc/BRIEF.md
# Shared Work-RAM Mapper for Two Processor Ports

This block divides a 32 KiB shared work RAM between two processor ports, port A and port B, under a 2-bit allocation setting. The shared RAM is built as two independent 16 KiB banks, the low half and the high half. Each half belongs to exactly one port at any time, so both ports can complete an access in the same clock cycle without arbitration. Port A also has a private 16 KiB RAM. Port A uses this private RAM for the upper part of its window, and for its whole window when it owns no shared RAM.

Each port issues byte, halfword or word accesses with a size code. Write data is taken right-aligned, and read data returns one cycle later, right-aligned and zero-extended. A single register write loads the allocation setting from the low two bits of a written byte. The new setting applies from the next cycle, so an access in the same cycle as the write still uses the old mapping. An access from port B while port B owns nothing reads zero, changes no memory, and raises a flag for one cycle.

Top module: `wram_share_mapper`

## Requirements
- R1: After reset the allocation setting is 3: port A owns the full 32 KiB and port B owns nothing.
- R2: A setting write stores only bits [1:0] of `cfg_wdata`. Bits [7:2] are ignored.
- R3: Setting 0 gives both halves to port B, which sees shared byte (address AND 0x7FFF). Port A then maps its whole window to its private RAM.
- R4: Setting 1 gives the low half (shared bytes 0x0000-0x3FFF) to port A and the high half (0x4000-0x7FFF) to port B.
- R5: Setting 2 gives the high half to port A and the low half to port B.
- R6: A port that owns one half sees half offset (address AND 0x3FFF). A port that owns both halves sees shared offset (address AND 0x7FFF). The owned region therefore repeats across the port's whole window.
- R7: Size code 0 is a byte, 1 is a halfword, and 2 or 3 is a word. A halfword access clears address bit 0 and a word access clears bits [1:0]. Bytes are little-endian within a word, and reads are right-aligned and zero-extended.
- R8: A port A address at or above 0x8000 goes to the private RAM at offset (address AND 0x3FFF). This also holds for every port A address when port A owns no half.
- R9: When port B owns nothing, a port B read returns zero and a port B write changes no memory. `b_unmapped` is high in the cycle after any such port B access and low otherwise.
- R10: Read data appears in the cycle after a read request. In the cycle after a write or an idle cycle, the port's read data is zero.
- R11: A setting change takes effect on the cycle after the write. An access in the same cycle as the write uses the previous setting.
- R12: Both ports may access in the same cycle. No half is ever addressed by both ports at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Allocation setting write strobe |
| cfg_wdata | input | 8 | Written byte; low two bits are the setting |
| a_en | input | 1 | Port A access request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_size | input | 2 | Port A size code |
| a_addr | input | 16 | Port A byte address |
| a_wdata | input | 32 | Port A write data, right-aligned |
| a_rdata | output | 32 | Port A read data, one cycle after the request |
| b_en | input | 1 | Port B access request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_size | input | 2 | Port B size code |
| b_addr | input | 16 | Port B byte address |
| b_wdata | input | 32 | Port B write data, right-aligned |
| b_rdata | output | 32 | Port B read data, one cycle after the request |
| b_unmapped | output | 1 | One-cycle flag for a port B access while it owns nothing |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that `a_we` and `b_we` only matter when the matching enable is high. The bench keeps to these assumptions: it holds reset for several cycles and drives every input away from the active edge. The random phase draws all settings, sizes, and any 16-bit address for both ports, and issues setting writes at arbitrary times, including cycles with accesses in flight. The bench first fills both RAMs through port A. This leaves every location holding a known value before any read is checked.

// File: rtl/wram_pkg.sv
package wram_pkg;

    typedef enum logic [1:0] {
        T_NONE = 2'd0,
        T_LO   = 2'd1,
        T_HI   = 2'd2,
        T_PRIV = 2'd3
    } tgt_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    // Ownership of one shared half under a setting.
    function automatic logic owns_half(input logic port_a, input logic [1:0] cfg,
                                       input logic hi);
        logic r;
        if (port_a) r = hi ? (cfg == 2'd2 || cfg == 2'd3) : (cfg == 2'd1 || cfg == 2'd3);
        else        r = hi ? (cfg == 2'd0 || cfg == 2'd1) : (cfg == 2'd0 || cfg == 2'd2);
        return r;
    endfunction

endpackage

// File: rtl/wram_alloc_reg.sv
module wram_alloc_reg #(
    parameter logic [1:0] RESET_CFG = 2'd3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [1:0] cfg
);
    logic [1:0] cfg_d, cfg_q;
    logic [5:0] unused_hi;

    always_comb begin
        cfg_d     = cfg_q;
        unused_hi = cfg_wdata[7:2];
        if (cfg_we) cfg_d = cfg_wdata[1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= RESET_CFG;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    p_reset_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cfg_q == RESET_CFG);
    p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_q == $past(cfg_wdata[1:0]));
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));

endmodule

// File: rtl/wram_port_route.sv
module wram_port_route
    import wram_pkg::*;
#(
    parameter int          AW           = 16,
    parameter int          SHARED_BYTES = 32768,
    parameter int          PRIV_BYTES   = 16384,
    parameter int          PRIV_BASE    = 32768,
    parameter bit          IS_A         = 1'b1,
    parameter int          IDX_W        = 12
) (
    input  logic [1:0]       cfg,
    input  logic             en,
    input  logic [1:0]       size,
    input  logic [AW-1:0]    addr,
    input  logic [31:0]      wdata,
    output tgt_e             tgt,
    output logic [IDX_W-1:0] widx,
    output logic [1:0]       lane,
    output logic [3:0]       be,
    output logic [31:0]      wlane
);
    localparam int          HALF_BYTES = SHARED_BYTES / 2;
    localparam int          HALF_BIT   = $clog2(HALF_BYTES);
    localparam logic [AW-1:0] SH_MASK   = AW'(SHARED_BYTES - 1);
    localparam logic [AW-1:0] HALF_MASK = AW'(HALF_BYTES - 1);
    localparam logic [AW-1:0] PRIV_MASK = AW'(PRIV_BYTES - 1);

    logic          own_lo, own_hi, to_priv;
    logic [AW-1:0] aligned, off;

    assign own_lo = owns_half(IS_A, cfg, 1'b0);
    assign own_hi = owns_half(IS_A, cfg, 1'b1);

    generate
        if (IS_A) begin : g_fallback
            assign to_priv = (!own_lo && !own_hi) ||
                             ({1'b0, aligned} >= (AW+1)'(PRIV_BASE));
        end else begin : g_no_fallback
            assign to_priv = 1'b0;
        end
    endgenerate

    always_comb begin
        aligned = addr;
        case (size)
            SZ_BYTE: ;
            SZ_HALF: aligned[0] = 1'b0;
            default: aligned[1:0] = 2'b00;
        endcase
        lane = aligned[1:0];
        case (size)
            SZ_BYTE: begin be = 4'b0001 << lane; wlane = {4{wdata[7:0]}};  end
            SZ_HALF: begin be = 4'b0011 << lane; wlane = {2{wdata[15:0]}}; end
            default: begin be = 4'b1111;         wlane = wdata;            end
        endcase

        off = '0;
        tgt = T_NONE;
        if (en) begin
            if (to_priv) begin
                off = aligned & PRIV_MASK;
                tgt = T_PRIV;
            end else if (own_lo && own_hi) begin
                off = aligned & SH_MASK;
                tgt = off[HALF_BIT] ? T_HI : T_LO;
            end else if (own_lo) begin
                off = aligned & HALF_MASK;
                tgt = T_LO;
            end else if (own_hi) begin
                off = aligned & HALF_MASK;
                tgt = T_HI;
            end
        end
        widx = IDX_W'(off >> 2);
    end

endmodule

// File: rtl/wram_bank.sv
module wram_bank #(
    parameter int WORDS = 4096,
    parameter int IW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [3:0]    be,
    input  logic [IW-1:0] idx,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    logic [31:0] mem [WORDS];
    logic [31:0] rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (en && !we) rd_d = mem[idx];
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
        if (en && we) begin
            for (int i = 0; i < 4; i++) begin
                if (be[i]) mem[idx][8*i +: 8] <= wdata[8*i +: 8];
            end
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/wram_read_fmt.sv
module wram_read_fmt
    import wram_pkg::*;
(
    input  logic        valid,
    input  logic [31:0] word,
    input  logic [1:0]  lane,
    input  logic [1:0]  size,
    output logic [31:0] data
);
    logic [31:0] shifted;

    always_comb begin
        shifted = word >> {lane, 3'b000};
        data    = '0;
        if (valid) begin
            case (size)
                SZ_BYTE: data = {24'h0, shifted[7:0]};
                SZ_HALF: data = {16'h0, shifted[15:0]};
                default: data = shifted;
            endcase
        end
    end

endmodule

// File: rtl/wram_share_mapper.sv
module wram_share_mapper
    import wram_pkg::*;
#(
    parameter int AW           = 16,
    parameter int SHARED_BYTES = 32768,
    parameter int PRIV_BASE    = 32768
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [1:0]    a_size,
    input  logic [AW-1:0] a_addr,
    input  logic [31:0]   a_wdata,
    output logic [31:0]   a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [1:0]    b_size,
    input  logic [AW-1:0] b_addr,
    input  logic [31:0]   b_wdata,
    output logic [31:0]   b_rdata,
    output logic          b_unmapped
);
    localparam int HALF_BYTES = SHARED_BYTES / 2;
    localparam int PRIV_BYTES = HALF_BYTES;
    localparam int HALF_WORDS = HALF_BYTES / 4;
    localparam int IDX_W      = $clog2(HALF_WORDS);

    typedef struct packed {
        logic       a_rd;
        tgt_e       a_tgt;
        logic [1:0] a_lane;
        logic [1:0] a_size;
        logic       b_rd;
        tgt_e       b_tgt;
        logic [1:0] b_lane;
        logic [1:0] b_size;
        logic       b_unm;
    } rsp_t;

    logic [1:0]       cfg_q;
    tgt_e             a_tgt, b_tgt;
    logic [IDX_W-1:0] a_widx, b_widx;
    logic [1:0]       a_lane, b_lane;
    logic [3:0]       a_be, b_be;
    logic [31:0]      a_wl, b_wl;
    logic [31:0]      half_rd [2];
    logic [31:0]      priv_rd;
    logic [31:0]      a_word, b_word;
    rsp_t             rsp_d, rsp_q;

    wram_alloc_reg #(.RESET_CFG(2'd3)) u_alloc (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg(cfg_q)
    );

    wram_port_route #(
        .AW(AW), .SHARED_BYTES(SHARED_BYTES), .PRIV_BYTES(PRIV_BYTES),
        .PRIV_BASE(PRIV_BASE), .IS_A(1'b1), .IDX_W(IDX_W)
    ) u_route_a (
        .cfg(cfg_q), .en(a_en), .size(a_size), .addr(a_addr), .wdata(a_wdata),
        .tgt(a_tgt), .widx(a_widx), .lane(a_lane), .be(a_be), .wlane(a_wl)
    );

    wram_port_route #(
        .AW(AW), .SHARED_BYTES(SHARED_BYTES), .PRIV_BYTES(PRIV_BYTES),
        .PRIV_BASE(PRIV_BASE), .IS_A(1'b0), .IDX_W(IDX_W)
    ) u_route_b (
        .cfg(cfg_q), .en(b_en), .size(b_size), .addr(b_addr), .wdata(b_wdata),
        .tgt(b_tgt), .widx(b_widx), .lane(b_lane), .be(b_be), .wlane(b_wl)
    );

    // One bank per shared half; the owning port drives it.
    generate
        for (genvar h = 0; h < 2; h++) begin : g_half
            localparam tgt_e MY_TGT = (h == 0) ? T_LO : T_HI;
            logic             sel_a, sel_b;
            logic             h_en, h_we;
            logic [3:0]       h_be;
            logic [IDX_W-1:0] h_idx;
            logic [31:0]      h_wd;

            always_comb begin
                sel_a = (a_tgt == MY_TGT);
                sel_b = (b_tgt == MY_TGT);
                h_en  = sel_a || sel_b;
                h_we  = sel_a ? a_we   : b_we;
                h_be  = sel_a ? a_be   : b_be;
                h_idx = sel_a ? a_widx : b_widx;
                h_wd  = sel_a ? a_wl   : b_wl;
            end

            wram_bank #(.WORDS(HALF_WORDS), .IW(IDX_W)) u_bank (
                .clk(clk), .en(h_en), .we(h_we), .be(h_be), .idx(h_idx),
                .wdata(h_wd), .rdata(half_rd[h])
            );

            p_half_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
                !(sel_a && sel_b));
        end
    endgenerate

    wram_bank #(.WORDS(HALF_WORDS), .IW(IDX_W)) u_priv (
        .clk(clk), .en(a_tgt == T_PRIV), .we(a_we), .be(a_be), .idx(a_widx),
        .wdata(a_wl), .rdata(priv_rd)
    );

    always_comb begin
        rsp_d        = rsp_q;
        rsp_d.a_rd   = a_en && !a_we;
        rsp_d.a_tgt  = a_tgt;
        rsp_d.a_lane = a_lane;
        rsp_d.a_size = a_size;
        rsp_d.b_rd   = b_en && !b_we && (b_tgt != T_NONE);
        rsp_d.b_tgt  = b_tgt;
        rsp_d.b_lane = b_lane;
        rsp_d.b_size = b_size;
        rsp_d.b_unm  = b_en && (b_tgt == T_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    always_comb begin
        case (rsp_q.a_tgt)
            T_LO:    a_word = half_rd[0];
            T_HI:    a_word = half_rd[1];
            default: a_word = priv_rd;
        endcase
        case (rsp_q.b_tgt)
            T_LO:    b_word = half_rd[0];
            T_HI:    b_word = half_rd[1];
            default: b_word = '0;
        endcase
    end

    wram_read_fmt u_fmt_a (
        .valid(rsp_q.a_rd), .word(a_word), .lane(rsp_q.a_lane),
        .size(rsp_q.a_size), .data(a_rdata)
    );

    wram_read_fmt u_fmt_b (
        .valid(rsp_q.b_rd), .word(b_word), .lane(rsp_q.b_lane),
        .size(rsp_q.b_size), .data(b_rdata)
    );

    assign b_unmapped = rsp_q.b_unm;

    p_b_dead_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && cfg_q == 2'd3) |=> (b_unmapped && b_rdata == 32'h0));
    p_b_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q != 2'd3) |=> !b_unmapped);
    p_a_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_en && !a_we) |=> a_rdata == 32'h0);
    p_a_private_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && cfg_q == 2'd0) |-> a_tgt == T_PRIV);

endmodule

// File: tb/wram_share_mapper_tb.sv
`timescale 1ns/1ps
module wram_share_mapper_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [7:0]  cfg_wdata;
    logic        a_en, a_we, b_en, b_we;
    logic [1:0]  a_size, b_size;
    logic [15:0] a_addr, b_addr;
    logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic        b_unmapped;

    int checks = 0;
    int errors = 0;

    logic [7:0] sh [32768];
    logic [7:0] pv [16384];
    logic [1:0] mcfg;

    always #10 clk = ~clk;

    wram_share_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .a_en(a_en), .a_we(a_we), .a_size(a_size), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_size(b_size), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_unmapped(b_unmapped)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    // kind: 0 none, 1 shared, 2 private
    function automatic void route(input bit isa, input logic [1:0] cfg,
                                  input logic [15:0] addr, input logic [1:0] sz,
                                  output int kind, output int phys);
        logic [15:0] al;
        al = addr;
        if (sz == 2'd1) al[0] = 1'b0;
        else if (sz != 2'd0) al[1:0] = 2'b00;
        kind = 1;
        phys = 0;
        if (isa) begin
            if (cfg == 2'd0 || al >= 16'h8000) begin
                kind = 2; phys = int'(al & 16'h3FFF);
            end else if (cfg == 2'd3) phys = int'(al & 16'h7FFF);
            else if (cfg == 2'd1) phys = int'(al & 16'h3FFF);
            else phys = 32'h4000 | int'(al & 16'h3FFF);
        end else begin
            if (cfg == 2'd3) kind = 0;
            else if (cfg == 2'd0) phys = int'(al & 16'h7FFF);
            else if (cfg == 2'd1) phys = 32'h4000 | int'(al & 16'h3FFF);
            else phys = int'(al & 16'h3FFF);
        end
    endfunction

    function automatic logic [31:0] mread(input int kind, input int phys, input int n);
        logic [31:0] v = '0;
        for (int i = 0; i < n; i++)
            v[8*i +: 8] = (kind == 1) ? sh[phys + i] : pv[phys + i];
        return v;
    endfunction

    task automatic mwrite(input int kind, input int phys, input int n, input logic [31:0] d);
        for (int i = 0; i < n; i++) begin
            if (kind == 1) sh[phys + i] = d[8*i +: 8];
            else if (kind == 2) pv[phys + i] = d[8*i +: 8];
        end
    endtask

    // Called at a falling edge; drives one cycle and checks the response.
    task automatic step(input bit aen, input bit awe, input logic [1:0] asz,
                        input logic [15:0] aad, input logic [31:0] awd,
                        input bit ben, input bit bwe, input logic [1:0] bsz,
                        input logic [15:0] bad, input logic [31:0] bwd,
                        input bit cwe, input logic [7:0] cwd, input string tag);
        int ka, pa, kb, pb;
        logic [31:0] ea, eb;
        logic eu;
        a_en = aen; a_we = awe; a_size = asz; a_addr = aad; a_wdata = awd;
        b_en = ben; b_we = bwe; b_size = bsz; b_addr = bad; b_wdata = bwd;
        cfg_we = cwe; cfg_wdata = cwd;
        route(1'b1, mcfg, aad, asz, ka, pa);
        route(1'b0, mcfg, bad, bsz, kb, pb);
        ea = (aen && !awe) ? mread(ka, pa, nbytes(asz)) : 32'h0;
        eb = (ben && !bwe && kb != 0) ? mread(kb, pb, nbytes(bsz)) : 32'h0;
        eu = ben && (kb == 0);
        if (aen && awe) mwrite(ka, pa, nbytes(asz), awd);
        if (ben && bwe) mwrite(kb, pb, nbytes(bsz), bwd);
        if (cwe) mcfg = cwd[1:0];
        @(posedge clk);
        @(negedge clk);
        check(tag, "a_rdata", a_rdata, ea);
        check(tag, "b_rdata", b_rdata, eb);
        check(tag, "b_unmapped", {31'h0, b_unmapped}, {31'h0, eu});
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h0, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        cfg_we = 0; cfg_wdata = 0;
        a_en = 0; a_we = 0; a_size = 0; a_addr = 0; a_wdata = 0;
        b_en = 0; b_we = 0; b_size = 0; b_addr = 0; b_wdata = 0;
        mcfg = 2'd3;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, idle outputs and port B unmapped
        idle("R1");
        step(0, 0, 0, 0, 0, 1, 0, 2'd2, 16'h0010, 0, 0, 8'h0, "R1_b_read_unmapped");

        // Fill shared (setting 3) and private RAM through port A
        for (int i = 0; i < 8192; i++)
            step(1, 1, 2'd2, 16'(i * 4), $urandom, 0, 0, 0, 0, 0, 0, 8'h0, "R1_fill");
        for (int i = 0; i < 4096; i++)
            step(1, 1, 2'd2, 16'h8000 + 16'(i * 4), $urandom, 0, 0, 0, 0, 0, 0, 8'h0, "R8_fill");

        // R9: port B write in setting 3 is dropped, read stays zero
        step(0, 0, 0, 0, 0, 1, 1, 2'd2, 16'h0040, 32'hDEADBEEF, 0, 8'h0, "R9_write_dropped");
        step(1, 0, 2'd2, 16'h0040, 0, 0, 0, 0, 0, 0, 0, 8'h0, "R9_readback");
        idle("R9_flag_clears");

        // R2 and R11: upper bits ignored; same-cycle access uses old setting
        step(1, 0, 2'd2, 16'h4000, 0, 1, 0, 2'd2, 16'h0000, 0, 1, 8'hFE, "R11_old_mapping");
        step(1, 0, 2'd2, 16'h0000, 0, 1, 0, 2'd2, 16'h0000, 0, 0, 8'h0, "R2_R5_new_mapping");

        // R4: setting 1 (written as 0x05), mirroring R6
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h05, "R2");
        step(1, 0, 2'd2, 16'h7FFC, 0, 1, 0, 2'd2, 16'hC004, 0, 0, 8'h0, "R4_R6_mirror");
        step(1, 1, 2'd2, 16'h0100, 32'h11223344, 1, 1, 2'd2, 16'h0100, 32'h55667788, 0, 8'h0, "R12_both_write");
        step(1, 0, 2'd2, 16'h4100, 0, 1, 0, 2'd2, 16'h8100, 0, 0, 8'h0, "R12_both_read");

        // R7: sub-word sizes and alignment
        step(1, 0, 2'd0, 16'h0103, 0, 1, 0, 2'd0, 16'h0102, 0, 0, 8'h0, "R7_byte");
        step(1, 0, 2'd1, 16'h0103, 0, 1, 0, 2'd1, 16'h0101, 0, 0, 8'h0, "R7_half");
        step(1, 0, 2'd3, 16'h0103, 0, 1, 0, 2'd3, 16'h0102, 0, 0, 8'h0, "R7_word_code3");
        step(1, 1, 2'd0, 16'h0101, 32'hFFFFFFAB, 0, 0, 0, 0, 0, 0, 8'h0, "R7_byte_write");
        step(1, 0, 2'd2, 16'h0100, 0, 0, 0, 0, 0, 0, 0, 8'h0, "R7_byte_merge");

        // R3: setting 0, port A goes private; R8 private mirror
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h00, "R3");
        step(1, 0, 2'd2, 16'h0010, 0, 1, 0, 2'd2, 16'hC010, 0, 0, 8'h0, "R3_R8_private");
        step(1, 0, 2'd2, 16'hC010, 0, 1, 0, 2'd2, 16'h4010, 0, 0, 8'h0, "R8_private_mirror");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h02, "R5");
        step(1, 0, 2'd2, 16'h0010, 0, 1, 0, 2'd2, 16'h4010, 0, 0, 8'h0, "R5_swap");
        idle("R10_idle");

        // Random mix across all settings
        for (int i = 0; i < 6000; i++) begin
            bit cw = ($urandom % 16) == 0;
            step($urandom % 4 != 0, $urandom % 2, 2'($urandom % 4), 16'($urandom), $urandom,
                 $urandom % 4 != 0, $urandom % 2, 2'($urandom % 4), 16'($urandom), $urandom,
                 cw, 8'($urandom), "R12_random");
        end
        idle("R10");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule